// File: doc/BRIEF.md
# Quad countdown timer

This peripheral holds four 32-bit countdown channels that share one APB slave port. Each channel has its own 64-byte register window, its own interrupt line and its own mask. Software writes a start value, selects single-shot or continuous-reload behaviour, and enables the channel. The channel then counts down by one per clock. When the count steps off 1, the channel raises its pending flag. In continuous mode the count restarts from the start value on the same edge. In single-shot mode the count parks at zero.

A pending flag is cleared with a short handshake. A write of 1 to the clear field starts a fixed busy window of two cycles. During that window a busy bit reads high and further clear writes are dropped. A status word that gathers the pending flags of all channels can be read at the bottom of every window, so one read serves the handler of any channel. Software can also read the live count, force a reload by writing any value to a reload register, and retarget the start value.

APB transfers complete with no wait states and never flag an error. The block has no streaming data path, so the valid/ready style does not apply. All of its pins are plain control and status.

Top module: `quad_countdown_timer`

## Requirements
- R1: After reset every channel reads mode 0, load 0, enable 0, count 0, clear 0 and mask 1; the status word reads 0 and all interrupt outputs are low.
- R2: Channel n occupies byte addresses n*0x40 to n*0x40+0x3F. Within a window the registers sit at these offsets: 0x00 status word (read-only), 0x04 mode (bit 0), 0x08 load value (32 bits), 0x10 enable (bit 0), 0x14 reload (write-only, reads 0), 0x18 live count (read-only), 0x20 clear (bit 0 is pending, bit 1 is busy), 0x24 mask (bit 0). Any other offset, including an unaligned one, reads 0 and ignores writes. Writes to the read-only registers are ignored. pready is always 1 and pslverr is always 0.
- R3: A write to enable with bit 0 = 1 copies the load value into the counter and starts it. A write with bit 0 = 0 stops the counter after that edge, and the count then holds.
- R4: While enabled with a count above 1, the count drops by one per clock. The pending flag sets on the edge where the count leaves 1, which is exactly L clocks after the enabling write for a load value L.
- R5: In continuous mode (mode bit 0 = 0) the timeout edge reloads the load value, giving a period of L clocks.
- R6: In single mode (mode bit 0 = 1) the timeout edge leaves the count at 0. A count of 0 stays 0 until software writes it.
- R7: A write of any data to the reload register copies the load value into the counter.
- R8: A write to the load register while the channel is disabled also sets the counter to that value. While the channel is enabled, such a write leaves the running count alone.
- R9: A write with clear bit 0 = 1 while busy is 0 drops the pending flag and holds busy (clear bit 1) at 1 for exactly two cycles. A write with bit 0 = 0 has no effect.
- R10: While busy is 1, clear writes are ignored. A timeout that falls during the busy window, or on the clearing edge itself, leaves the pending flag set.
- R11: The interrupt output of a channel equals its pending flag while the mask bit is 0 and is low while the mask bit is 1. The status word and the clear register show the pending flag whatever the mask.
- R12: Bit n of the status word, read at offset 0x00 of any window, is the pending flag of channel n.
- R13: The full 32-bit range works: a load value of 0xFFFFFFFF is loaded and counts down without truncation.
- R14: Channels are independent: registers, counting and interrupts of one channel do not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for bus and counters |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address (channel index in bits 7:6) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| irq_o | output | 4 | Per-channel interrupt, pending AND NOT mask |

## Verification
A count register that is off by one appears in the next live-count read, and it moves the interrupt edge by one clock. The bench therefore measures the timeout cycle against the enabling write, and does this for every channel, both modes and several load values. A busy counter that is too long or too short changes what the clear register returns one and three cycles after a clear. It also decides whether a clear written two cycles later is dropped. A wrong priority between timeout and clear shows up as a pending flag that is missing immediately after the clearing edge. Most internal faults therefore reach the ports within one or two APB transfers.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int WIN_W  = 6;
  localparam int DATA_W = 32;

  localparam logic [WIN_W-1:0] OFF_STAT = 6'h00;
  localparam logic [WIN_W-1:0] OFF_MODE = 6'h04;
  localparam logic [WIN_W-1:0] OFF_LOAD = 6'h08;
  localparam logic [WIN_W-1:0] OFF_EN   = 6'h10;
  localparam logic [WIN_W-1:0] OFF_RLD  = 6'h14;
  localparam logic [WIN_W-1:0] OFF_CNT  = 6'h18;
  localparam logic [WIN_W-1:0] OFF_CLR  = 6'h20;
  localparam logic [WIN_W-1:0] OFF_MASK = 6'h24;

  typedef enum logic {
    MODE_CONT = 1'b0,
    MODE_ONE  = 1'b1
  } run_mode_e;
endpackage

// File: rtl/qct_apb_decode.sv
module qct_apb_decode
  import qct_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = IDX_W + WIN_W
) (
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata,
  input  logic [NUM_CH-1:0]             sts_vec,
  output logic [NUM_CH-1:0]             ch_wr,
  output logic [WIN_W-1:0]              off,
  output logic [DATA_W-1:0]             prdata
);
  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx = paddr[ADDR_W-1:WIN_W];
  assign off = paddr[WIN_W-1:0];
  assign hit = (int'(idx) < NUM_CH);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_wr
    assign ch_wr[n] = psel && penable && pwrite && hit && (idx == IDX_W'(n));
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && hit) begin
      if (off == OFF_STAT) prdata[NUM_CH-1:0] = sts_vec;
      else                 prdata = ch_rdata[idx];
    end
  end
endmodule

// File: rtl/qct_clr_hs.sv
module qct_clr_hs #(
  parameter int CLR_BUSY_CYC = 2,
  localparam int BW = $clog2(CLR_BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  output logic sts,
  output logic busy
);
  logic [BW-1:0] busy_cnt;
  logic          accept;

  assign accept = clr_req && (busy_cnt == '0);
  assign busy   = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      sts      <= 1'b0;
    end else begin
      if (accept)                busy_cnt <= BW'(CLR_BUSY_CYC);
      else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
      // timeout outranks a clear on the same edge
      if (expire)                sts <= 1'b1;
      else if (accept)           sts <= 1'b0;
    end
  end
endmodule

// File: rtl/qct_channel.sv
module qct_channel
  import qct_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int CLR_BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WIN_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              sts_o,
  output logic              busy_o,
  output logic              irq_o
);
  run_mode_e        mode;
  logic [CNT_W-1:0] ld;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             en;
  logic             mask;
  logic             expire;
  logic             wr_mode, wr_load, wr_en, wr_rld, wr_clr, wr_mask;

  assign wr_mode = wr_stb && (off == OFF_MODE);
  assign wr_load = wr_stb && (off == OFF_LOAD);
  assign wr_en   = wr_stb && (off == OFF_EN);
  assign wr_rld  = wr_stb && (off == OFF_RLD);
  assign wr_clr  = wr_stb && (off == OFF_CLR);
  assign wr_mask = wr_stb && (off == OFF_MASK);

  assign expire = en && (cnt == CNT_W'(1));

  always_comb begin
    cnt_nxt = cnt;
    if (en && (cnt != '0))
      cnt_nxt = (expire && (mode == MODE_CONT)) ? ld : cnt - 1'b1;
    if (wr_load && !en)    cnt_nxt = wdata[CNT_W-1:0];
    if (wr_en && wdata[0]) cnt_nxt = ld;
    if (wr_rld)            cnt_nxt = ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_CONT;
      ld   <= '0;
      cnt  <= '0;
      en   <= 1'b0;
      mask <= 1'b1;
    end else begin
      if (wr_mode) mode <= run_mode_e'(wdata[0]);
      if (wr_load) ld   <= wdata[CNT_W-1:0];
      if (wr_en)   en   <= wdata[0];
      if (wr_mask) mask <= wdata[0];
      cnt <= cnt_nxt;
    end
  end

  qct_clr_hs #(.CLR_BUSY_CYC(CLR_BUSY_CYC)) u_clr (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .clr_req (wr_clr && wdata[0]),
    .sts     (sts_o),
    .busy    (busy_o)
  );

  always_comb begin
    rdata = '0;
    case (off)
      OFF_MODE: rdata[0]         = mode;
      OFF_LOAD: rdata[CNT_W-1:0] = ld;
      OFF_EN:   rdata[0]         = en;
      OFF_CNT:  rdata[CNT_W-1:0] = cnt;
      OFF_CLR:  rdata[1:0]       = {busy_o, sts_o};
      OFF_MASK: rdata[0]         = mask;
      default:  rdata            = '0;
    endcase
  end

  assign cnt_o = cnt;
  assign en_o  = en;
  assign irq_o = sts_o && !mask;
endmodule

// File: rtl/quad_countdown_timer.sv
module quad_countdown_timer
  import qct_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int CNT_W        = 32,
  parameter int CLR_BUSY_CYC = 2,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = IDX_W + WIN_W
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0]             ch_sts;
  logic [NUM_CH-1:0]             ch_busy;
  logic [NUM_CH-1:0]             ch_wr;
  logic [WIN_W-1:0]              off;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  qct_apb_decode #(.NUM_CH(NUM_CH)) u_dec (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .ch_rdata (ch_rdata),
    .sts_vec  (ch_sts),
    .ch_wr    (ch_wr),
    .off      (off),
    .prdata   (prdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    qct_channel #(.CNT_W(CNT_W), .CLR_BUSY_CYC(CLR_BUSY_CYC)) u_ch (
      .clk    (pclk),
      .rst_n  (presetn),
      .wr_stb (ch_wr[n]),
      .off    (off),
      .wdata  (pwdata),
      .rdata  (ch_rdata[n]),
      .cnt_o  (ch_cnt[n]),
      .en_o   (ch_en[n]),
      .sts_o  (ch_sts[n]),
      .busy_o (ch_busy[n]),
      .irq_o  (irq_o[n])
    );
  end
endmodule

// File: rtl/qct_chk.sv
module qct_chk
  import qct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = IDX_W + WIN_W
) (
  input logic                         pclk,
  input logic                         presetn,
  input logic                         psel,
  input logic                         pwrite,
  input logic [ADDR_W-1:0]            paddr,
  input logic [DATA_W-1:0]            pwdata,
  input logic [DATA_W-1:0]            prdata,
  input logic                         pready,
  input logic                         pslverr,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            ch_sts,
  input logic [NUM_CH-1:0]            ch_busy,
  input logic [NUM_CH-1:0]            ch_wr
);
  // R2
  apb_resp_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  // R12
  status_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && (paddr[WIN_W-1:0] == OFF_STAT) && (int'(paddr[ADDR_W-1:WIN_W]) < NUM_CH))
    |-> (prdata[NUM_CH-1:0] == ch_sts));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    // R4
    dec_step_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (ch_en[i] && (ch_cnt[i] > CNT_W'(1)) && !ch_wr[i])
      |=> (ch_cnt[i] == CNT_W'($past(ch_cnt[i]) - 1'b1)));

    // R6
    zero_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      ((ch_cnt[i] == '0) && !ch_wr[i]) |=> (ch_cnt[i] == '0));

    // R10
    expire_sts_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (ch_en[i] && (ch_cnt[i] == CNT_W'(1))) |=> ch_sts[i]);

    // R9
    clr_busy_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (ch_wr[i] && (paddr[WIN_W-1:0] == OFF_CLR) && pwdata[0] && !ch_busy[i])
      |=> ch_busy[i]);
  end
endmodule

bind quad_countdown_timer qct_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_qct_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .pready  (pready),
  .pslverr (pslverr),
  .ch_cnt  (ch_cnt),
  .ch_en   (ch_en),
  .ch_sts  (ch_sts),
  .ch_busy (ch_busy),
  .ch_wr   (ch_wr)
);

// File: tb/quad_countdown_timer_bench.sv
`timescale 1ns/1ps
module quad_countdown_timer_bench;
  import qct_pkg::*;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [NCH-1:0] irq;

  int total = 0, bad = 0, cyc = 0, wr_cyc = 0, rd_cyc = 0, resp_err = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quad_countdown_timer u_quad_countdown_timer (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [5:0] off, input logic [31:0] d);
    paddr = AW'(ch * 64 + int'(off)); pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
    @(negedge clk); penable = 1'b1; wr_cyc = cyc + 1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [5:0] off, output logic [31:0] d);
    paddr = AW'(ch * 64 + int'(off)); pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #0.5; d = prdata; rd_cyc = cyc;
    if (!pready || pslverr) resp_err++;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rdchk(input string tag, input int ch, input logic [5:0] off, input logic [31:0] exp);
    logic [31:0] v;
    rd(ch, off, v);
    chk(tag, v, exp);
  endtask

  task automatic quiet(input int ch);
    wr(ch, OFF_EN, 0);
    wr(ch, OFF_CLR, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int e, k, rbase;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    for (int ch = 0; ch < NCH; ch++) begin
      rdchk("R1 mode", ch, OFF_MODE, 0);
      rdchk("R1 load", ch, OFF_LOAD, 0);
      rdchk("R1 en", ch, OFF_EN, 0);
      rdchk("R1 cnt", ch, OFF_CNT, 0);
      rdchk("R1 clr", ch, OFF_CLR, 0);
      rdchk("R1 mask", ch, OFF_MASK, 1);
      rdchk("R1 status", ch, OFF_STAT, 0);
    end

    // R2 unmapped offsets and read-only writes
    wr(0, OFF_LOAD, 32'h1234);
    wr(0, 6'h0C, 32'hFFFF_FFFF);
    wr(0, OFF_CNT, 32'h0);
    wr(0, 6'h09, 32'h5);
    rdchk("R2 load kept", 0, OFF_LOAD, 32'h1234);
    rdchk("R2 cnt kept", 0, OFF_CNT, 32'h1234);
    rdchk("R2 hole 0C", 0, 6'h0C, 0);
    rdchk("R2 hole 1C", 0, 6'h1C, 0);
    rdchk("R2 hole 28", 0, 6'h28, 0);
    rdchk("R2 hole 3C", 0, 6'h3C, 0);
    rdchk("R2 unaligned", 0, 6'h09, 0);
    rdchk("R2 reload reads 0", 0, OFF_RLD, 0);

    // R2 R14 window separation
    for (int ch = 0; ch < NCH; ch++) wr(ch, OFF_LOAD, 32'h100 + 32'(ch) * 32'h11);
    for (int ch = 0; ch < NCH; ch++) begin
      rdchk("R14 load window", ch, OFF_LOAD, 32'h100 + 32'(ch) * 32'h11);
      rdchk("R8 cnt follows load", ch, OFF_CNT, 32'h100 + 32'(ch) * 32'h11);
    end

    // R4 R5 R6 R14 sweep: every channel, both modes, several loads
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 2; m++) begin
        for (int li = 0; li < 4; li++) begin
          int L;
          L = (li == 0) ? 3 : (li == 1) ? 4 : (li == 2) ? 7 : 15;
          quiet(ch);
          wr(ch, OFF_MASK, 0);
          wr(ch, OFF_MODE, 32'(m));
          wr(ch, OFF_LOAD, 32'(L));
          wr(ch, OFF_EN, 1);
          k = -1;
          for (int t = 0; t < 40; t++) begin
            if (irq[ch]) begin k = cyc - wr_cyc; break; end
            @(negedge clk);
          end
          chk("R4 timeout cycle", 32'(k), 32'(L));
          chk("R14 other irqs low", 32'(irq & ~(NCH'(1) << ch)), 0);
          rd(ch, OFF_CNT, v);
          k = rd_cyc - wr_cyc;
          if (m == 0) chk("R5 continuous count", v, 32'(L - (k % L)));
          else        chk("R6 single count", v, (k < L) ? 32'(L - k) : 0);
          rdchk("R4 pending in clr", ch, OFF_CLR, 1);
          quiet(ch);
        end
      end
    end

    // R3 stop holds count
    wr(0, OFF_MODE, 1);
    wr(0, OFF_LOAD, 1000);
    wr(0, OFF_EN, 1); e = wr_cyc;
    rd(0, OFF_CNT, v);
    chk("R3 start count", v, 32'(1000 - (rd_cyc - e)));
    wr(0, OFF_EN, 0);
    k = wr_cyc - e;
    rd(0, OFF_CNT, v);
    chk("R3 stopped count", v, 32'(1000 - k));
    rd(0, OFF_CNT, v2);
    chk("R3 count holds", v2, v);

    // R7 reload with any data
    wr(0, OFF_EN, 1);
    repeat (5) @(negedge clk);
    wr(0, OFF_RLD, 0); rbase = wr_cyc;
    rd(0, OFF_CNT, v);
    chk("R7 reload data0", v, 32'(1000 - (rd_cyc - rbase)));
    repeat (3) @(negedge clk);
    wr(0, OFF_RLD, 1); rbase = wr_cyc;
    rd(0, OFF_CNT, v);
    chk("R7 reload data1", v, 32'(1000 - (rd_cyc - rbase)));

    // R8 load while running does not disturb count
    wr(0, OFF_LOAD, 50);
    rd(0, OFF_CNT, v);
    chk("R8 running count kept", v, 32'(1000 - (rd_cyc - rbase)));
    wr(0, OFF_RLD, 5); rbase = wr_cyc;
    rd(0, OFF_CNT, v);
    chk("R7 reload new load", v, 32'(50 - (rd_cyc - rbase)));
    quiet(0);

    // R9 clear handshake
    wr(1, OFF_MODE, 1); wr(1, OFF_MASK, 0); wr(1, OFF_LOAD, 5); wr(1, OFF_EN, 1);
    repeat (10) @(negedge clk);
    chk("R9 irq before clear", 32'(irq[1]), 1);
    wr(1, OFF_CLR, 0);
    rdchk("R9 write0 no effect", 1, OFF_CLR, 1);
    wr(1, OFF_CLR, 1);
    rdchk("R9 busy after clear", 1, OFF_CLR, 2);
    chk("R9 irq dropped", 32'(irq[1]), 0);
    rdchk("R9 busy ended", 1, OFF_CLR, 0);

    // R10 clear ignored while busy, timeout inside busy window
    quiet(2);
    wr(2, OFF_MODE, 1); wr(2, OFF_MASK, 0); wr(2, OFF_LOAD, 3);
    wr(2, OFF_EN, 1);
    wr(2, OFF_CLR, 1);
    wr(2, OFF_CLR, 1);
    rdchk("R10 second clear ignored", 2, OFF_CLR, 1);
    chk("R10 irq still high", 32'(irq[2]), 1);
    // R10 timeout on the clearing edge wins
    quiet(2);
    wr(2, OFF_LOAD, 2);
    wr(2, OFF_EN, 1);
    wr(2, OFF_CLR, 1);
    rdchk("R10 timeout beats clear", 2, OFF_CLR, 3);

    // R11 mask
    quiet(3);
    wr(3, OFF_MASK, 1); wr(3, OFF_MODE, 1); wr(3, OFF_LOAD, 4); wr(3, OFF_EN, 1);
    repeat (8) @(negedge clk);
    chk("R11 masked irq low", 32'(irq[3]), 0);
    rdchk("R11 clr shows pending", 3, OFF_CLR, 1);
    wr(3, OFF_MASK, 0);
    chk("R11 unmasked irq high", 32'(irq[3]), 1);
    wr(3, OFF_MASK, 1);
    chk("R11 remasked irq low", 32'(irq[3]), 0);

    // R12 status word in every window
    for (int ch = 0; ch < NCH; ch++) rdchk("R12 status word", ch, OFF_STAT, 32'hC);
    wr(2, OFF_CLR, 1);
    rdchk("R12 status after clear", 0, OFF_STAT, 32'h8);
    rdchk("R12 status other window", 1, OFF_STAT, 32'h8);

    // R13 full range
    quiet(0);
    wr(0, OFF_MODE, 0);
    wr(0, OFF_LOAD, 32'hFFFF_FFFF);
    rdchk("R13 full load", 0, OFF_CNT, 32'hFFFF_FFFF);
    wr(0, OFF_EN, 1); e = wr_cyc;
    rd(0, OFF_CNT, v);
    chk("R13 full count", v, 32'hFFFF_FFFF - 32'(rd_cyc - e));
    rd(0, OFF_CNT, v);
    chk("R13 full count later", v, 32'hFFFF_FFFF - 32'(rd_cyc - e));
    chk("R14 no stray irq", 32'(irq[0]), 0);

    chk("R2 pready/pslverr", 32'(resp_err), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule